// File: doc/BRIEF.md
# Parallel Port Host Register Window

This block gives a host a byte-wide register view of a PC-style parallel port. An 8-location I/O window, aligned to a base address (0x378 by default), is decoded on its low three address bits. It holds a data latch that drives the port's data pins, a read-only status view of the printer status lines, a control register whose low bits drive the control pins, and two enhanced-port locations. The enhanced-port locations hand each access to an external cycle engine as a single-cycle request and wait for a done pulse.

A write to the control register also sets the direction of the data pins: the direction bit is consumed and is never kept as a register bit. The acknowledge line from the printer raises the interrupt only while the control register enables it. A status read lowers the interrupt again. An enhanced-port cycle that gets no answer within a set number of cycles ends with a timeout flag in the status register.

Top module: `lpt_host_regs`

## Requirements
- R1: After reset, pd_out is 0x00, pd_oe is 1 (forward), irq is 0, ctl_lines is 0, a control read returns 0xC0 and the status timeout bit (bit 0) is 0.
- R2: An access is answered only when bus_addr[ADDR_W-1:3] equals BASE[ADDR_W-1:3]. Outside the window there is no bus_ack and no state changes. bus_addr[2:0] picks the register.
- R3: Only bus_size 0 (one byte) is a real access. A read with any other size is acked with bus_unused 1 and data 0xFF. A write with any other size is acked and changes nothing.
- R4: At offset 0, a write stores the byte and drives it on pd_out. A read returns the stored byte while the direction is forward, and pd_in while it is reverse.
- R5: A status read (offset 1) returns {line_status[4:0], irq, 1'b0, timeout}, with line_status[4] in bit 7 (busy) down to line_status[0] in bit 3 (error). The read lowers irq on the next cycle and clears the timeout bit.
- R6: In a control write (offset 2), bits 7:6 are forced to 1. Bit 5 sets the direction: 1 means reverse, so pd_oe goes to 0. The value is stored with bit 5 cleared, ctl_lines shows bits 3:0, and ctl_upd pulses for one cycle.
- R7: A control write whose value after forcing bits 7:6 (bit 5 as written) equals the stored value changes nothing: there is no ctl_upd pulse and the direction stays as it was.
- R8: An ack_evt pulse sets irq only while stored control bit 4 is 1. Otherwise irq stays low.
- R9: Offsets 5 to 7 read 0xFF with bus_unused 0, and writes to them change nothing.
- R10: A byte write to offset 3 (address) or 4 (data) sends a one-cycle epp_req with epp_wr 1. epp_addr_sel is 1 for offset 3, and epp_wdata is the byte. bus_ack follows the cycle in which epp_done is sampled.
- R11: A byte read of offset 3 or 4 sends epp_req with epp_wr 0 and returns the epp_din value sampled together with epp_done.
- R12: If epp_done does not come within TMO_CYC cycles of the request, the access is acked with 0xFF and status bit 0 is set.
- R13: Every access to offsets 0, 1, 2 or 5 to 7, and every non-byte access, is acked in the cycle right after the request. While an enhanced-port cycle is outstanding, new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_size | input | 2 | Access size code, 0 = one byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with bus_ack |
| bus_ack | output | 1 | Access completion pulse |
| bus_unused | output | 1 | Read of a non-byte size |
| pd_out | output | 8 | Data pins, outbound |
| pd_in | input | 8 | Data pins, inbound |
| pd_oe | output | 1 | Data pin drive enable (1 = forward) |
| ctl_lines | output | 4 | Strobe, auto-feed, init, select-in levels |
| ctl_upd | output | 1 | Pulse on a control register update |
| line_status | input | 5 | Busy, ack, paper-out, select, error |
| ack_evt | input | 1 | Acknowledge event pulse |
| irq | output | 1 | Interrupt request |
| epp_req | output | 1 | Cycle request to the enhanced-port engine |
| epp_wr | output | 1 | Request direction, 1 = write |
| epp_addr_sel | output | 1 | 1 = address cycle, 0 = data cycle |
| epp_wdata | output | 8 | Write byte for the engine |
| epp_din | input | 8 | Read byte from the engine |
| epp_done | input | 1 | Engine completion pulse |

## Verification
A request presented before edge E0 gets its bus_ack right after E0 for plain registers. For enhanced-port accesses the ack comes one edge after the edge that samples epp_done, and on a missing answer it comes exactly TMO_CYC edges after E0. Pin effects such as pd_out, pd_oe, ctl_lines and ctl_upd change at E0, and irq changes at the edge that samples ack_evt. The bench drives on falling edges and counts falling edges from the request to the ack, so it checks the exact latency as well as the value, and it samples every pin outcome at the first falling edge where it is due.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      OFF_DATA = 3'd0,
      OFF_STAT = 3'd1,
      OFF_CTRL = 3'd2,
      OFF_EADR = 3'd3,
      OFF_EDAT = 3'd4
   } reg_off_e;

   localparam logic [BYTE_W-1:0] CTRL_RESV = 8'hC0;
   localparam logic [BYTE_W-1:0] CTRL_DIR  = 8'h20;
   localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
   localparam logic [1:0]        SIZE_BYTE = 2'd0;
endpackage

// File: rtl/lpt_addr_dec.sv
module lpt_addr_dec
   import lpt_pkg::*;
#(
   parameter int              ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE = 'h378
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic              hit,
   output logic              byte_ok,
   output reg_off_e          off
);
   generate
      if (ADDR_W < 4) begin : g_bad_width
         $error("ADDR_W too small for an 8-location window");
      end
      if (BASE[2:0] != 3'd0) begin : g_bad_base
         $error("BASE must be 8-location aligned");
      end
   endgenerate

   assign hit     = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
   assign byte_ok = (size == SIZE_BYTE);
   assign off     = reg_off_e'(addr[2:0]);
endmodule

// File: rtl/lpt_epp_hs.sv
module lpt_epp_hs
   import lpt_pkg::*;
#(
   parameter int TMO_CYC = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_wr,
   input  logic              start_adr,
   input  logic [BYTE_W-1:0] start_data,
   input  logic              epp_done,
   output logic              epp_req,
   output logic              epp_wr,
   output logic              epp_addr_sel,
   output logic [BYTE_W-1:0] epp_wdata,
   output logic              busy,
   output logic              fin_ok,
   output logic              fin_tmo
);
   generate
      if (TMO_CYC < 0) begin : g_bad_tmo
         $error("TMO_CYC must not be negative");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epp_req      <= 1'b0;
         epp_wr       <= 1'b0;
         epp_addr_sel <= 1'b0;
         epp_wdata    <= '0;
         busy         <= 1'b0;
      end else begin
         epp_req <= start;
         if (start) begin
            busy         <= 1'b1;
            epp_wr       <= start_wr;
            epp_addr_sel <= start_adr;
            epp_wdata    <= start_data;
         end else if (fin_ok || fin_tmo) begin
            busy <= 1'b0;
         end
      end
   end

   assign fin_ok = busy && epp_done;

   generate
      if (TMO_CYC == 0) begin : g_no_tmo
         assign fin_tmo = 1'b0;
      end else begin : g_tmo
         localparam int CW = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC + 1);
         localparam logic [CW-1:0] LIM = CW'(TMO_CYC - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (start)
               cnt <= '0;
            else if (busy && !epp_done && cnt != LIM)
               cnt <= cnt + 1'b1;
         end
         assign fin_tmo = busy && !epp_done && (cnt == LIM);
      end
   endgenerate

   AST_EPP_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      epp_req |=> !epp_req); // R10
   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R13
endmodule

// File: rtl/lpt_irq_ctl.sv
module lpt_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic en,
   input  logic clr,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq <= 1'b0;
      else if (evt && en)
         irq <= 1'b1;
      else if (clr)
         irq <= 1'b0;
   end

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(evt && en)); // R8
endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
   import lpt_pkg::*;
#(
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] BASE    = 'h378,
   parameter int                TMO_CYC = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              bus_ack,
   output logic              bus_unused,
   output logic [7:0]        pd_out,
   input  logic [7:0]        pd_in,
   output logic              pd_oe,
   output logic [3:0]        ctl_lines,
   output logic              ctl_upd,
   input  logic [4:0]        line_status,
   input  logic              ack_evt,
   output logic              irq,
   output logic              epp_req,
   output logic              epp_wr,
   output logic              epp_addr_sel,
   output logic [7:0]        epp_wdata,
   input  logic [7:0]        epp_din,
   input  logic              epp_done
);
   logic        hit, byte_ok, busy, fin_ok, fin_tmo;
   reg_off_e    off;
   logic        acc, epp_start, stat_rd;
   logic [BYTE_W-1:0] data_q, ctrl_q, rdata_q, ctrl_wr_val, stat_val;
   logic        rev_q, tmo_q, ack_q, unused_q, upd_q;

   lpt_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .addr(bus_addr), .size(bus_size), .hit(hit), .byte_ok(byte_ok), .off(off)
   );

   assign acc       = bus_req && hit && !busy;
   assign epp_start = acc && byte_ok && (off == OFF_EADR || off == OFF_EDAT);
   assign stat_rd   = acc && byte_ok && !bus_wr && (off == OFF_STAT);

   lpt_epp_hs #(.TMO_CYC(TMO_CYC)) u_epp (
      .clk(clk), .rst_n(rst_n),
      .start(epp_start), .start_wr(bus_wr), .start_adr(off == OFF_EADR),
      .start_data(bus_wdata), .epp_done(epp_done),
      .epp_req(epp_req), .epp_wr(epp_wr), .epp_addr_sel(epp_addr_sel),
      .epp_wdata(epp_wdata), .busy(busy), .fin_ok(fin_ok), .fin_tmo(fin_tmo)
   );

   lpt_irq_ctl u_irq (
      .clk(clk), .rst_n(rst_n), .evt(ack_evt), .en(ctrl_q[4]),
      .clr(stat_rd), .irq(irq)
   );

   assign ctrl_wr_val = bus_wdata | CTRL_RESV;
   assign stat_val    = {line_status, irq, 1'b0, tmo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         ctrl_q   <= CTRL_RESV;
         rev_q    <= 1'b0;
         tmo_q    <= 1'b0;
         ack_q    <= 1'b0;
         unused_q <= 1'b0;
         upd_q    <= 1'b0;
         rdata_q  <= '0;
      end else begin
         ack_q    <= 1'b0;
         unused_q <= 1'b0;
         upd_q    <= 1'b0;
         if (fin_ok) begin
            ack_q   <= 1'b1;
            rdata_q <= epp_wr ? FILL_BYTE : epp_din;
         end else if (fin_tmo) begin
            ack_q   <= 1'b1;
            rdata_q <= FILL_BYTE;
            tmo_q   <= 1'b1;
         end else if (acc) begin
            if (!byte_ok) begin
               ack_q    <= 1'b1;
               unused_q <= !bus_wr;
               rdata_q  <= FILL_BYTE;
            end else begin
               case (off)
                  OFF_DATA: begin
                     ack_q <= 1'b1;
                     if (bus_wr) data_q  <= bus_wdata;
                     else        rdata_q <= rev_q ? pd_in : data_q;
                  end
                  OFF_STAT: begin
                     ack_q <= 1'b1;
                     if (!bus_wr) begin
                        rdata_q <= stat_val;
                        tmo_q   <= 1'b0;
                     end
                  end
                  OFF_CTRL: begin
                     ack_q <= 1'b1;
                     if (bus_wr) begin
                        if (ctrl_wr_val != ctrl_q) begin
                           rev_q  <= ctrl_wr_val[5];
                           ctrl_q <= ctrl_wr_val & ~CTRL_DIR;
                           upd_q  <= 1'b1;
                        end
                     end else begin
                        rdata_q <= ctrl_q;
                     end
                  end
                  OFF_EADR, OFF_EDAT: begin
                     ack_q <= 1'b0;
                  end
                  default: begin
                     ack_q   <= 1'b1;
                     rdata_q <= FILL_BYTE;
                  end
               endcase
            end
         end
      end
   end

   assign bus_ack    = ack_q;
   assign bus_unused = unused_q;
   assign bus_rdata  = rdata_q;
   assign pd_out     = data_q;
   assign pd_oe      = !rev_q;
   assign ctl_lines  = ctrl_q[3:0];
   assign ctl_upd    = upd_q;

   AST_OE_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pd_oe) |-> ctl_upd); // R6
   AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ack_evt) |=> !irq); // R5
   AST_TMO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_q) |-> (bus_ack && bus_rdata == FILL_BYTE)); // R12
   AST_LINES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctl_lines) |-> ctl_upd); // R7
endmodule

// File: tb/lpt_host_regs_test.sv
`timescale 1ns/1ps
module lpt_host_regs_test;
   localparam int TMO = 16;
   localparam logic [15:0] BASE = 16'h378;

   logic clk = 0, rst_n = 0;
   logic bus_req = 0, bus_wr = 0;
   logic [15:0] bus_addr = '0;
   logic [1:0] bus_size = '0;
   logic [7:0] bus_wdata = '0, bus_rdata, pd_out, pd_in = 8'h00, epp_wdata, epp_din = '0;
   logic bus_ack, bus_unused, pd_oe, ctl_upd, irq, epp_req, epp_wr, epp_addr_sel;
   logic [3:0] ctl_lines;
   logic [4:0] line_status = 5'h00;
   logic ack_evt = 0, epp_done = 0;

   int nchk = 0, nbad = 0;
   bit finished = 0;
   bit resp_on = 1;
   int resp_lat = 0;
   logic [7:0] resp_val = 8'h00;
   logic seen_wr, seen_sel;
   logic [7:0] seen_d;

   logic [7:0] data_m = 8'h00, ctrl_m = 8'hC0;
   bit rev_m = 0, irq_m = 0, tmo_m = 0;

   always #4 clk = ~clk;

   lpt_host_regs #(.ADDR_W(16), .BASE(BASE), .TMO_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_unused(bus_unused),
      .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .ctl_lines(ctl_lines),
      .ctl_upd(ctl_upd), .line_status(line_status), .ack_evt(ack_evt), .irq(irq),
      .epp_req(epp_req), .epp_wr(epp_wr), .epp_addr_sel(epp_addr_sel),
      .epp_wdata(epp_wdata), .epp_din(epp_din), .epp_done(epp_done)
   );

   task automatic chk(input string r, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_stat();
      return {line_status, irq_m, 1'b0, tmo_m};
   endfunction

   // engine model for enhanced-port cycles
   initial begin
      forever begin
         @(negedge clk);
         if (epp_req) begin
            seen_wr = epp_wr; seen_sel = epp_addr_sel; seen_d = epp_wdata;
            if (resp_on) begin
               repeat (resp_lat) @(negedge clk);
               epp_din = resp_val; epp_done = 1;
               @(negedge clk);
               epp_done = 0;
            end
         end
      end
   end

   task automatic acc(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                      input logic [7:0] wd, output logic [7:0] rd, output bit un,
                      output int k, output bit up);
      @(negedge clk);
      bus_req = 1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
      @(negedge clk);
      bus_req = 0;
      up = ctl_upd;
      k = 0;
      while (!bus_ack && k < 60) begin @(negedge clk); k++; end
      if (!bus_ack) k = -1;
      rd = bus_rdata; un = bus_unused;
   endtask

   task automatic wreg(input logic [2:0] o, input logic [7:0] v, input string r, output bit up);
      logic [7:0] rd; bit un; int k;
      acc(1, BASE + 16'(o), 2'd0, v, rd, un, k, up);
      chk({r, " R13 latency"}, k, 0);
   endtask

   task automatic rreg(input logic [2:0] o, input string r, output logic [7:0] rd);
      bit un, up; int k;
      acc(0, BASE + 16'(o), 2'd0, 8'h00, rd, un, k, up);
      chk({r, " R13 latency"}, k, 0);
   endtask

   task automatic ctrl_write(input logic [7:0] v, input string r);
      bit up; logic [7:0] f; bit eu;
      f = v | 8'hC0; eu = (f != ctrl_m);
      if (eu) begin rev_m = f[5]; ctrl_m = f & 8'hDF; end
      wreg(3'd2, v, r, up);
      chk({r, " upd"}, up, eu);
      chk({r, " oe"}, pd_oe, !rev_m);
      chk({r, " lines"}, ctl_lines, ctrl_m[3:0]);
   endtask

   task automatic pulse_ack(input string r);
      @(negedge clk); ack_evt = 1;
      @(negedge clk); ack_evt = 0;
      if (ctrl_m[4]) irq_m = 1;
      chk(r, irq, irq_m);
   endtask

   task automatic stat_read(input string r);
      logic [7:0] rd, e;
      e = exp_stat();
      rreg(3'd1, r, rd);
      chk(r, rd, e);
      irq_m = 0; tmo_m = 0;
      chk({r, " irq cleared"}, irq, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nchk++; nbad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd; bit un, up; int k;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pd_out", pd_out, 8'h00);
      chk("R1 pd_oe", pd_oe, 1);
      chk("R1 irq", irq, 0);
      chk("R1 lines", ctl_lines, 0);
      rreg(3'd2, "R1 ctrl", rd); chk("R1 ctrl", rd, 8'hC0);
      line_status = 5'h15;
      stat_read("R1 status");

      // R2 window decode
      acc(0, 16'h0388, 2'd0, 8'h00, rd, un, k, up);
      chk("R2 outside no ack", k, -1);
      acc(1, 16'h027A, 2'd0, 8'h3F, rd, un, k, up);
      chk("R2 outside write no ack", k, -1);
      rreg(3'd2, "R2 ctrl kept", rd); chk("R2 ctrl kept", rd, 8'hC0);

      // R4 data register
      wreg(3'd0, 8'hA5, "R4 write", up); data_m = 8'hA5;
      chk("R4 pd_out", pd_out, 8'hA5);
      rreg(3'd0, "R4 fwd read", rd); chk("R4 fwd read", rd, 8'hA5);
      ctrl_write(8'h20, "R6 reverse");
      rreg(3'd2, "R6 ctrl read", rd); chk("R6 ctrl read", rd, 8'hC0);
      pd_in = 8'h3C;
      rreg(3'd0, "R4 rev read", rd); chk("R4 rev read", rd, 8'h3C);
      // R7 equal value: no update, stays reverse
      ctrl_write(8'h00, "R7 equal");
      chk("R7 still reverse", pd_oe, 0);
      ctrl_write(8'h0B, "R6 forward");

      // R3 non-byte sizes
      acc(0, BASE + 16'd1, 2'd1, 8'h00, rd, un, k, up);
      chk("R3 unused", un, 1); chk("R3 fill", rd, 8'hFF); chk("R3 R13 latency", k, 0);
      acc(1, BASE, 2'd2, 8'h11, rd, un, k, up);
      chk("R3 write ignored", pd_out, 8'hA5); chk("R3 write unused", un, 0);
      rreg(3'd0, "R3 data kept", rd); chk("R3 data kept", rd, 8'hA5);

      // R9 unused offsets
      for (int o = 5; o < 8; o++) begin
         acc(0, BASE + 16'(o), 2'd0, 8'h00, rd, un, k, up);
         chk("R9 read fill", rd, 8'hFF); chk("R9 unused flag", un, 0);
      end
      wreg(3'd6, 8'h00, "R9 write", up);
      chk("R9 pd_out kept", pd_out, 8'hA5); chk("R9 lines kept", ctl_lines, 4'hB);

      // R8 / R5 interrupt
      pulse_ack("R8 disabled");
      ctrl_write(8'h10, "R8 enable");
      pulse_ack("R8 enabled");
      line_status = 5'h0A;
      stat_read("R5 status irq");
      stat_read("R5 status again");

      // R10 enhanced-port writes
      resp_on = 1; resp_lat = 2;
      acc(1, BASE + 16'd3, 2'd0, 8'h77, rd, un, k, up);
      chk("R10 latency", k, 3); chk("R10 wr", seen_wr, 1);
      chk("R10 addr sel", seen_sel, 1); chk("R10 data", seen_d, 8'h77);
      resp_lat = 0;
      acc(1, BASE + 16'd4, 2'd0, 8'h88, rd, un, k, up);
      chk("R10 data sel", seen_sel, 0); chk("R10 latency 0", k, 1);
      // R11 read
      resp_val = 8'h9C;
      acc(0, BASE + 16'd4, 2'd0, 8'h00, rd, un, k, up);
      chk("R11 read data", rd, 8'h9C); chk("R11 wr", seen_wr, 0); chk("R11 latency", k, 1);
      // R12 timeout
      resp_on = 0;
      acc(0, BASE + 16'd3, 2'd0, 8'h00, rd, un, k, up);
      chk("R12 latency", k, TMO); chk("R12 fill", rd, 8'hFF);
      tmo_m = 1;
      stat_read("R12 status bit");
      stat_read("R12 cleared");

      // R13 request ignored while busy
      resp_on = 1; resp_lat = 4; resp_val = 8'h41;
      @(negedge clk);
      bus_req = 1; bus_wr = 0; bus_addr = BASE + 16'd4; bus_size = 0;
      @(negedge clk); bus_req = 0;
      @(negedge clk);
      bus_req = 1; bus_wr = 1; bus_addr = BASE; bus_wdata = 8'h5A;
      @(negedge clk); bus_req = 0;
      k = 0;
      while (!bus_ack && k < 60) begin @(negedge clk); k++; end
      chk("R13 epp data", bus_rdata, 8'h41);
      repeat (3) @(negedge clk);
      chk("R13 busy write ignored", pd_out, 8'hA5);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [7:0] v;
         op = $urandom_range(0, 6);
         v = 8'($urandom);
         pd_in = 8'($urandom);
         line_status = 5'($urandom);
         case (op)
            0: begin wreg(3'd0, v, "R4 rnd write", up); data_m = v; chk("R4 rnd pd_out", pd_out, data_m); end
            1: begin rreg(3'd0, "R4 rnd read", rd); chk("R4 rnd read", rd, rev_m ? pd_in : data_m); end
            2: ctrl_write(v, "R6 rnd ctrl");
            3: begin rreg(3'd2, "R6 rnd ctrl read", rd); chk("R6 rnd ctrl read", rd, ctrl_m); end
            4: stat_read("R5 rnd status");
            5: pulse_ack("R8 rnd ack");
            default: begin
               acc(0, BASE + 16'($urandom_range(5, 7)), 2'd0, 8'h00, rd, un, k, up);
               chk("R9 rnd fill", rd, 8'hFF);
            end
         endcase
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule